// File: doc/BRIEF.md
# Receiver Error Interrupt Aggregator

This block gathers error pulses from a camera serial receiver and turns them into one level-sensitive interrupt. Eight protocol error sources (payload checksum, header error-correction outcomes, data identifier, reserved short packets and the three kinds of truncation) and one FIFO overflow source per output stream each arrive as single-cycle pulses. Each pulse sets its own sticky bit in a status register. An enable register picks which of those bits may raise the interrupt line.

Software services the interrupt by reading the status register and writing the same value back. Every 1 in the written value clears its bit. A pulse that arrives in the same cycle as the clear of its own bit wins, so no event is lost. The register port is a plain write strobe with a byte offset, plus a combinational read on a separate offset.

Top module: `csi_err_irq_unit`

## Requirements
- R1: A pulse on `proto_err_i[k]` sets status bit 4+k for k = 0..3 and bit 5+k for k = 4..7. The bit is visible at offset 0x28 from the cycle after the pulse and stays set until it is cleared.
- R2: A pulse on `ovf_i[s]` sets status bit 16+s, and the bit stays set until it is cleared.
- R3: A write to offset 0x28 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R5: A write to offset 0x2C loads the enable register, which reads back at 0x2C. Writing 0 there keeps the interrupt low whatever the status.
- R6: `irq_o` is high exactly when some status bit is set and its enable bit is set. Status bits still latch while their enable bit is clear.
- R7: At both offsets, every bit other than 4..7, 9..12 and 16..16+NUM_STREAMS-1 reads as 0 and ignores writes.
- R8: After reset, status and enable both read 0 and `irq_o` is low.
- R9: Reads from any other offset return 0, and writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proto_err_i | input | 8 | Protocol error pulses, one per source |
| ovf_i | input | NUM_STREAMS | Per-stream FIFO overflow pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | ADDR_W | Read byte offset |
| reg_rdata_o | output | 32 | Read data, combinational on `reg_raddr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land in the same cycle: a new error pulse and the write-1-to-clear of the bit that pulse targets. The bench sweeps every source one at a time. For each one it drives the pulse and a status write carrying that source's bit on the same edge, then reads back that the bit survived, while a clear on its own still empties the bit. The checker also flags any status bit that falls without a write of 1 to it in the cycle before.

// File: rtl/errirq_pkg.sv
// Shared layout helpers for the error interrupt aggregator.
// Assumes a 32-bit register width and at most 16 streams.
package errirq_pkg;
    localparam int REG_W    = 32;
    localparam int PROTO_N  = 8;
    localparam int OVF_BASE = 16;

    // Status bit position of protocol source k (bit 8 is skipped).
    function automatic int proto_pos(input int k);
        return (k < 4) ? (4 + k) : (5 + k);
    endfunction

    // Set of implemented status/enable bits for a given stream count.
    function automatic logic [REG_W-1:0] valid_bits(input int nstreams);
        logic [REG_W-1:0] v;
        v = '0;
        for (int k = 0; k < PROTO_N; k++) v[proto_pos(k)] = 1'b1;
        for (int s = 0; s < nstreams; s++) v[OVF_BASE + s] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/errirq_evt_map.sv
// Places the event pulses on their fixed status bit positions.
// Assumes the pulses are synchronous to the register clock.
module errirq_evt_map #(
    parameter int NUM_STREAMS = 4
) (
    input  logic [errirq_pkg::PROTO_N-1:0] proto_err_i,
    input  logic [NUM_STREAMS-1:0]         ovf_i,
    output logic [errirq_pkg::REG_W-1:0]   evt_vec_o
);
    // Scatter each pulse onto its bit; the other bits stay 0.
    always_comb begin
        evt_vec_o = '0;
        for (int k = 0; k < errirq_pkg::PROTO_N; k++)
            evt_vec_o[errirq_pkg::proto_pos(k)] = proto_err_i[k];
        for (int s = 0; s < NUM_STREAMS; s++)
            evt_vec_o[errirq_pkg::OVF_BASE + s] = ovf_i[s];
    end
endmodule

// File: rtl/errirq_sticky_bank.sv
// Sticky status bits with write-1-to-clear; a set beats a clear.
// Bits outside VALID are not built and read as 0.
module errirq_sticky_bank #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (VALID[b]) begin : g_flop
            logic q;
            // Hold, set on event, or clear on a written 1.
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= 1'b0;
                else if (set_i[b])          q <= 1'b1;
                else if (clr_en_i && clr_i[b]) q <= 1'b0;
            end
            assign status_o[b] = q;
        end else begin : g_zero
            assign status_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/errirq_mask_reg.sv
// Interrupt enable register; only implemented bits are stored.
module errirq_mask_reg #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] q;
    // Load written value filtered to implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (wr_i) q <= wdata_i & VALID;
    end
    assign mask_o = q;
endmodule

// File: rtl/csi_err_irq_unit.sv
// Top of the error interrupt aggregator: register decode, sticky
// status, enable register and the level interrupt output.
// Assumes single-cycle event pulses and one register write per cycle.
module csi_err_irq_unit #(
    parameter int                 NUM_STREAMS = 4,
    parameter int                 ADDR_W      = 12,
    parameter logic [ADDR_W-1:0]  STATUS_OFS  = 12'h028,
    parameter logic [ADDR_W-1:0]  ENABLE_OFS  = 12'h02C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [errirq_pkg::PROTO_N-1:0] proto_err_i,
    input  logic [NUM_STREAMS-1:0]       ovf_i,
    input  logic                         reg_wr_i,
    input  logic [ADDR_W-1:0]            reg_waddr_i,
    input  logic [errirq_pkg::REG_W-1:0] reg_wdata_i,
    input  logic [ADDR_W-1:0]            reg_raddr_i,
    output logic [errirq_pkg::REG_W-1:0] reg_rdata_o,
    output logic                         irq_o
);
    localparam int                 W          = errirq_pkg::REG_W;
    localparam logic [W-1:0]       VALID_BITS = errirq_pkg::valid_bits(NUM_STREAMS);

    logic [W-1:0] evt_vec;
    logic [W-1:0] status_q;
    logic [W-1:0] mask_q;
    logic         wr_status;
    logic         wr_mask;

    // Write strobes per register.
    assign wr_status = reg_wr_i && (reg_waddr_i == STATUS_OFS);
    assign wr_mask   = reg_wr_i && (reg_waddr_i == ENABLE_OFS);

    errirq_evt_map #(.NUM_STREAMS(NUM_STREAMS)) u_map (
        .proto_err_i (proto_err_i),
        .ovf_i       (ovf_i),
        .evt_vec_o   (evt_vec)
    );

    errirq_sticky_bank #(.W(W), .VALID(VALID_BITS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_vec),
        .clr_en_i (wr_status),
        .clr_i    (reg_wdata_i),
        .status_o (status_q)
    );

    errirq_mask_reg #(.W(W), .VALID(VALID_BITS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_q)
    );

    // Read mux: status, enable, else zero.
    always_comb begin
        if (reg_raddr_i == STATUS_OFS)      reg_rdata_o = status_q;
        else if (reg_raddr_i == ENABLE_OFS) reg_rdata_o = mask_q;
        else                                reg_rdata_o = '0;
    end

    // Level interrupt from any enabled pending bit.
    assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/csi_err_irq_chk.sv
// Protocol checker for csi_err_irq_unit, attached by bind.
module csi_err_irq_chk #(
    parameter int           ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h028,
    parameter logic [ADDR_W-1:0] ENABLE_OFS = 12'h02C,
    parameter logic [31:0]  VALID_BITS = 32'h0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_waddr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       status,
    input logic [31:0]       mask,
    input logic [31:0]       evt_vec,
    input logic              irq_o
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(evt_vec)) == $past(evt_vec))); // R4
    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_waddr_i == STATUS_OFS) |=> ((($past(status)) & ~status) == 32'h0)); // R3
    AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_waddr_i == STATUS_OFS) |=> ((($past(status)) & ~status & ~$past(reg_wdata_i)) == 32'h0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_waddr_i == ENABLE_OFS) |=> $stable(mask)); // R5
    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 32'h0) |-> !irq_o); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | mask) & ~VALID_BITS) == 32'h0); // R7
endmodule

bind csi_err_irq_unit csi_err_irq_chk #(
    .ADDR_W     (ADDR_W),
    .STATUS_OFS (STATUS_OFS),
    .ENABLE_OFS (ENABLE_OFS),
    .VALID_BITS (VALID_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_waddr_i (reg_waddr_i),
    .reg_wdata_i (reg_wdata_i),
    .status      (status_q),
    .mask        (mask_q),
    .evt_vec     (evt_vec),
    .irq_o       (irq_o)
);

// File: tb/csi_err_irq_unit_tb.sv
// Sweep bench: every source alone, the pulse/clear collision per source,
// and full-width writes, with expected values built from the bit layout.
module csi_err_irq_unit_tb;
    localparam int NS = 4;
    localparam logic [11:0] A_ST = 12'h028;
    localparam logic [11:0] A_EN = 12'h02C;
    localparam logic [11:0] A_OT = 12'h030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  proto = '0;
    logic [NS-1:0] ovf = '0;
    logic        wr = 1'b0;
    logic [11:0] waddr = '0;
    logic [31:0] wdata = '0;
    logic [11:0] raddr = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    csi_err_irq_unit #(.NUM_STREAMS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .proto_err_i(proto), .ovf_i(ovf),
        .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
        .reg_raddr_i(raddr), .reg_rdata_o(rdata), .irq_o(irq));

    // Expected bit position of source i: 0..7 protocol, 8.. overflow.
    function automatic int src_pos(input int i);
        if (i < 4) return 4 + i;
        if (i < 8) return 5 + i;
        return 16 + (i - 8);
    endfunction

    function automatic logic [31:0] all_valid();
        logic [31:0] v = '0;
        for (int i = 0; i < 8 + NS; i++) v[src_pos(i)] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, return at next negedge with inputs idle.
    task automatic step(input int src, input bit w, input logic [11:0] a, input logic [31:0] d);
        proto = '0; ovf = '0;
        if (src >= 0 && src < 8) proto[src] = 1'b1;
        if (src >= 8) ovf[src-8] = 1'b1;
        wr = w; waddr = a; wdata = d;
        @(negedge clk);
        proto = '0; ovf = '0; wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        raddr = a; #1; v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, bit_m, vb;
        vb = all_valid();
        repeat (3) @(negedge clk);
        rd(A_ST, v); chk("R8 status after reset", v, 32'h0);
        rd(A_EN, v); chk("R8 enable after reset", v, 32'h0);
        chk("R8 irq after reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8 + NS; i++) begin
            bit_m = 32'h1 << src_pos(i);
            step(i, 1'b0, A_ST, 32'h0);
            rd(A_ST, v);
            chk(i < 8 ? "R1 proto event sets bit" : "R2 overflow event sets bit", v, bit_m);
            chk("R6 masked event keeps irq low", {31'h0, irq}, 32'h0);
            step(-1, 1'b0, A_ST, 32'h0);
            rd(A_ST, v); chk("R1 bit is sticky", v, bit_m);
            step(-1, 1'b1, A_EN, bit_m);
            rd(A_EN, v); chk("R5 enable readback", v, bit_m);
            chk("R6 enabled bit raises irq", {31'h0, irq}, 32'h1);
            step(-1, 1'b1, A_EN, vb & ~bit_m);
            chk("R6 other enables keep irq low", {31'h0, irq}, 32'h0);
            step(-1, 1'b1, A_ST, ~bit_m);
            rd(A_ST, v); chk("R3 zero in write keeps bit", v, bit_m);
            step(i, 1'b1, A_ST, bit_m);
            rd(A_ST, v); chk("R4 event beats same-cycle clear", v, bit_m);
            step(-1, 1'b1, A_ST, bit_m);
            rd(A_ST, v); chk("R3 written one clears bit", v, 32'h0);
            step(-1, 1'b1, A_EN, 32'h0);
        end

        // All sources together, enable zero.
        proto = 8'hFF; ovf = '1;
        @(negedge clk);
        proto = '0; ovf = '0;
        rd(A_ST, v); chk("R1 all events", v, vb);
        chk("R5 zero enable blocks irq", {31'h0, irq}, 32'h0);
        step(-1, 1'b1, A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); chk("R7 enable unused bits read 0", v, vb);
        chk("R6 irq with all enabled", {31'h0, irq}, 32'h1);
        step(-1, 1'b1, A_OT, 32'h0);
        rd(A_EN, v); chk("R9 other offset write keeps enable", v, vb);
        rd(A_ST, v); chk("R9 other offset write keeps status", v, vb);
        rd(A_OT, v); chk("R9 other offset reads 0", v, 32'h0);
        step(-1, 1'b1, A_ST, ~vb);
        rd(A_ST, v); chk("R7 unused bit writes ignored", v, vb);
        step(-1, 1'b1, A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R3 full clear", v, 32'h0);
        chk("R6 irq drops after clear", {31'h0, irq}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule